// File: doc/BRIEF.md
# Detector Event Packet Builder

This block turns one event of front-end hit data into a single serial packet. Each event is offered with a single-cycle strobe. The strobe carries the 4-bit bunch crossing tag, the hit count, and a few control flags: a raw-readout mode flag, a downstream-buffer-full flag and a filler request. The builder picks one packet variant, reports its length in bits, and then shifts the packet out one bit per cycle, most significant bit first within every field.

Per-hit data (channel index with a 5-bit amplitude) or raw 6-bit samples are pulled from an upstream store. The store presents its current entry combinationally, and the builder consumes it in any cycle where it raises `in_take`. In zero-suppressed operation the packet is either a normal packet or a 16-bit special packet. The normal packet carries a short count and one 10-bit word per hit. The special packet covers too many hits, truncation when the buffer is full, and link filler. In raw mode the packet has a fixed size and carries debug bytes and every channel's sample in channel order.

Top module: `evt_pkt_builder`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `in_take` are low. An event strobe accepted while idle makes `out_valid` high from the next cycle. The first bits of every zero-suppressed packet are the 4-bit bunch tag (MSB first) and then a type bit: 0 for normal, 1 for special.
- R2: With no flags set and a hit count of 63 or less, the packet is {tag, 0, 6-bit count}, followed by one word {7-bit channel, 3-bit amplitude} per hit, in pull order. Its length is 11 + 10·N bits, and `in_take` pulses exactly N times.
- R3: The 3-bit amplitude is the 5-bit amplitude divided by four and rounded to nearest, that is (a+2)>>2, saturated at 7. Values of 30 and 31 therefore give 7 rather than wrapping to 0.
- R4: With no flags set and a hit count above 63, the packet is the 16-bit word {tag, 1, 001, 8-bit count}, and no entry is pulled.
- R5: With the buffer-full flag set and no filler request, the packet is the 16-bit word {tag, 1, 010, 8-bit count}. This holds even when raw mode is also set or the count exceeds 63, and no entry is pulled.
- R6: A filler request takes priority over every other flag. It yields the 16-bit word {1111, 1, 100, 11111111}, whatever tag and count are given.
- R7: In raw mode, without the full or filler flag, the packet is 804 bits long. It carries the tag, then 32 debug bits, then 128 six-bit samples in pull order, with no type bit and no channel IDs. The debug bits hold four bytes, highest byte first: the final-pass channel count, the signal count, the recovered count and the signed common mode. `in_take` pulses 128 times.
- R8: `pkt_len` holds the packet length from the first bit to the last. `out_last` is high only with the final bit, and `out_valid` is low in the cycle after it.
- R9: An event strobe raised while a packet is being sent is ignored. The running packet is unchanged and no second packet follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe, accepted when idle |
| ev_bcid | input | 4 | Bunch crossing tag |
| ev_nhits | input | 8 | Hit count of the event |
| ev_nzs | input | 1 | Raw (non-zero-suppressed) mode |
| ev_full | input | 1 | Downstream buffer full |
| ev_fill | input | 1 | Filler packet request |
| ev_dbg | input | 32 | Debug bytes for raw mode |
| in_take | output | 1 | Consume current upstream entry this cycle |
| in_chan | input | 7 | Channel of current hit |
| in_amp | input | 5 | Amplitude of current hit |
| in_raw | input | 6 | Raw sample of current channel |
| out_valid | output | 1 | Serial bit valid |
| out_bit | output | 1 | Serial packet bit |
| out_last | output | 1 | Final bit of packet |
| pkt_len | output | 10 | Packet length in bits |

## Verification
The first packet bit and `pkt_len` appear in the cycle after the clock edge that samples the event strobe. Each later bit follows one cycle after the previous one. Each `in_take` falls in the cycle that carries the last bit of the preceding field, and the store must advance at that same edge. The bench drives inputs and samples outputs one nanosecond after the falling edge, and the store model advances on the rising edge that consumes an entry. Each whole stream is recorded bit by bit and compared against a packet built in the bench from the requirements, so every check lands on the cycle its result is due.

// File: rtl/evt_pkt_builder.sv
module evt_pkt_builder #(
  parameter int BC_W   = 4,
  parameter int CNT_W  = 8,
  parameter int NCNT_W = 6,
  parameter int CH_W   = 7,
  parameter int AMP_W  = 5,
  parameter int Q_W    = 3,
  parameter int RAW_W  = 6,
  parameter int NCH    = 128,
  parameter int DBG_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [BC_W-1:0]    ev_bcid,
  input  logic [CNT_W-1:0]   ev_nhits,
  input  logic               ev_nzs,
  input  logic               ev_full,
  input  logic               ev_fill,
  input  logic [DBG_W-1:0]   ev_dbg,
  output logic               in_take,
  input  logic [CH_W-1:0]    in_chan,
  input  logic [AMP_W-1:0]   in_amp,
  input  logic [RAW_W-1:0]   in_raw,
  output logic               out_valid,
  output logic               out_bit,
  output logic               out_last,
  output logic [9:0]         pkt_len
);
  localparam int NZ_MAX   = (1 << NCNT_W) - 1;
  localparam int NORM_HDR = BC_W + 1 + NCNT_W;
  localparam int HIT_W    = CH_W + Q_W;
  localparam int SPEC_W   = BC_W + 1 + 3 + CNT_W;
  localparam int NZS_HDR  = BC_W + DBG_W;
  localparam int NZS_LEN  = NZS_HDR + NCH * RAW_W;
  localparam int SR_W     = (NZS_HDR > SPEC_W) ? NZS_HDR : SPEC_W;
  localparam int FW       = $clog2(SR_W + 1);
  localparam int MAXI     = (NCH > NZ_MAX) ? NCH : NZ_MAX;
  localparam int IW       = $clog2(MAXI + 1);
  localparam int SH       = AMP_W - Q_W;
  localparam logic [2:0] FL_OVF  = 3'b001;
  localparam logic [2:0] FL_TRNC = 3'b010;
  localparam logic [2:0] FL_FILL = 3'b100;

  logic [SR_W-1:0] sr;
  logic [FW-1:0]   bcnt;
  logic [IW-1:0]   items;
  logic            body_raw;
  logic [9:0]      sent;

  logic [SR_W-1:0] st_val;
  logic [FW-1:0]   st_w;
  logic [IW-1:0]   st_items;
  logic [9:0]      st_len;
  logic            st_raw;

  logic [AMP_W:0]  amp_rnd;
  logic [Q_W:0]    amp_top;
  logic [Q_W-1:0]  amp_q;

  assign amp_rnd = {1'b0, in_amp} + (AMP_W+1)'(1 << (SH - 1));
  assign amp_top = amp_rnd[AMP_W:SH];
  assign amp_q   = amp_top[Q_W] ? {Q_W{1'b1}} : amp_top[Q_W-1:0];

  always_comb begin
    st_raw   = 1'b0;
    st_items = '0;
    st_w     = FW'(SPEC_W);
    st_len   = 10'(SPEC_W);
    if (ev_fill)
      st_val = SR_W'({{BC_W{1'b1}}, 1'b1, FL_FILL, {CNT_W{1'b1}}});
    else if (ev_full)
      st_val = SR_W'({ev_bcid, 1'b1, FL_TRNC, ev_nhits});
    else if (ev_nzs) begin
      st_val   = SR_W'({ev_bcid, ev_dbg});
      st_w     = FW'(NZS_HDR);
      st_len   = 10'(NZS_LEN);
      st_items = IW'(NCH);
      st_raw   = 1'b1;
    end else if (ev_nhits > CNT_W'(NZ_MAX))
      st_val = SR_W'({ev_bcid, 1'b1, FL_OVF, ev_nhits});
    else begin
      st_val   = SR_W'({ev_bcid, 1'b0, ev_nhits[NCNT_W-1:0]});
      st_w     = FW'(NORM_HDR);
      st_items = IW'(ev_nhits);
      st_len   = 10'(NORM_HDR) + 10'(HIT_W) * 10'(ev_nhits);
    end
  end

  assign out_bit  = sr[SR_W-1];
  assign out_last = out_valid && (bcnt == FW'(1)) && (items == '0);
  assign in_take  = out_valid && (bcnt == FW'(1)) && (items != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sr        <= '0;
      bcnt      <= '0;
      items     <= '0;
      body_raw  <= 1'b0;
      pkt_len   <= '0;
      sent      <= '0;
    end else if (!out_valid) begin
      if (ev_valid) begin
        out_valid <= 1'b1;
        sr        <= st_val << (FW'(SR_W) - st_w);
        bcnt      <= st_w;
        items     <= st_items;
        body_raw  <= st_raw;
        pkt_len   <= st_len;
        sent      <= '0;
      end
    end else begin
      sent <= sent + 10'd1;
      if (bcnt != FW'(1)) begin
        sr   <= sr << 1;
        bcnt <= bcnt - FW'(1);
      end else if (items != '0) begin
        items <= items - IW'(1);
        if (body_raw) begin
          sr   <= SR_W'(in_raw) << (SR_W - RAW_W);
          bcnt <= FW'(RAW_W);
        end else begin
          sr   <= SR_W'({in_chan, amp_q}) << (SR_W - HIT_W);
          bcnt <= FW'(HIT_W);
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && ev_valid) |=> out_valid);
  assert_take_in_pkt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |-> out_valid);
  assert_len_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(pkt_len));
  assert_last_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (sent + 10'd1 == pkt_len));
  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && $stable(pkt_len)));
  assert_fill_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && ev_valid && ev_fill) |=> (pkt_len == 10'(SPEC_W)));
endmodule

// File: tb/tb_evt_pkt_builder.sv
`timescale 1ns/1ps
module tb_evt_pkt_builder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_nzs = 1'b0, ev_full = 1'b0, ev_fill = 1'b0;
  logic [3:0] ev_bcid = '0;
  logic [7:0] ev_nhits = '0;
  logic [31:0] ev_dbg = '0;
  logic in_take, out_valid, out_bit, out_last;
  logic [6:0] in_chan;
  logic [4:0] in_amp;
  logic [5:0] in_raw;
  logic [9:0] pkt_len;

  always #2 clk = ~clk;

  evt_pkt_builder dut (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_bcid(ev_bcid),
    .ev_nhits(ev_nhits), .ev_nzs(ev_nzs), .ev_full(ev_full), .ev_fill(ev_fill),
    .ev_dbg(ev_dbg), .in_take(in_take), .in_chan(in_chan), .in_amp(in_amp),
    .in_raw(in_raw), .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
    .pkt_len(pkt_len));

  logic [6:0] hchan [0:255];
  logic [4:0] hamp  [0:255];
  logic [5:0] hraw  [0:255];
  int idx = 0;
  assign in_chan = hchan[idx];
  assign in_amp  = hamp[idx];
  assign in_raw  = hraw[idx];
  always @(posedge clk) if (in_take) idx <= idx + 1;

  int checks = 0, fails = 0;
  logic got [0:1023];
  logic expb [0:1023];
  int gn = 0, en = 0, lastcnt = 0, lastpos = -1, plen_bad = 0;
  logic [9:0] plen0;

  always @(negedge clk) if (out_valid) begin
    if (gn == 0) plen0 = pkt_len;
    else if (pkt_len != plen0) plen_bad++;
    got[gn] = out_bit;
    if (out_last) begin lastcnt++; lastpos = gn; end
    gn++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [35:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin expb[en] = v[i]; en++; end
  endtask

  function automatic logic [2:0] quant(input logic [4:0] a);
    int q;
    q = (int'(a) + 2) >> 2;
    if (q > 7) q = 7;
    return 3'(q);
  endfunction

  task automatic run_evt(input string req, input logic [3:0] bc, input logic [7:0] nh,
                         input logic nzs, input logic full, input logic fill,
                         input logic [31:0] dbg, input int exp_take, input logic poke);
    int bad;
    int t;
    en = 0;
    if (fill) push({4'hF, 1'b1, 3'b100, 8'hFF}, 16);
    else if (full) push({bc, 1'b1, 3'b010, nh}, 16);
    else if (nzs) begin
      push({bc, dbg}, 36);
      for (int k = 0; k < 128; k++) push(36'(hraw[k]), 6);
    end else if (nh > 63) push({bc, 1'b1, 3'b001, nh}, 16);
    else begin
      push({bc, 1'b0, nh[5:0]}, 11);
      for (int k = 0; k < int'(nh); k++) push({hchan[k], quant(hamp[k])}, 10);
    end
    @(negedge clk); #1;
    gn = 0; lastcnt = 0; lastpos = -1; plen_bad = 0; idx = 0;
    ev_bcid = bc; ev_nhits = nh; ev_nzs = nzs; ev_full = full; ev_fill = fill; ev_dbg = dbg;
    ev_valid = 1'b1;
    @(negedge clk); #1;
    ev_valid = 1'b0;
    chk(req, "out_valid after accept (R1)", int'(out_valid), 1);
    chk(req, "pkt_len (R8)", int'(pkt_len), en);
    t = 0;
    while (out_valid && t < 2000) begin
      if (poke && t == 5) begin ev_bcid = ~bc; ev_fill = 1'b1; ev_valid = 1'b1; end
      else ev_valid = 1'b0;
      @(negedge clk); #1; t++;
    end
    ev_valid = 1'b0; ev_fill = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(req, "bits sent", gn, en);
    bad = 0;
    for (int k = 0; k < en && k < gn; k++) if (got[k] !== expb[k]) bad++;
    chk(req, "mismatching bits", bad, 0);
    chk(req, "out_last count (R8)", lastcnt, 1);
    chk(req, "out_last position (R8)", lastpos, en - 1);
    chk(req, "pkt_len changes (R8)", plen_bad, 0);
    chk(req, "entries pulled", idx, exp_take);
    chk(req, "idle after packet", int'(out_valid), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) begin
      hchan[k] = 7'((k * 5 + 3) % 128);
      hamp[k]  = 5'((k * 7) % 32);
      hraw[k]  = 6'((k * 11 + 5) % 64);
    end
    hamp[0] = 5'd31; hamp[1] = 5'd1; hamp[2] = 5'd2; hamp[3] = 5'd29; hamp[4] = 5'd30;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset out_valid", int'(out_valid), 0);
    chk("R1", "reset in_take", int'(in_take), 0);
    chk("R1", "reset out_last", int'(out_last), 0);
    rst_n = 1'b1;
    chk("R3", "quant(31)", int'(quant(5'd31)), 7);
    run_evt("R2/R3 five hits", 4'hA, 8'd5, 1'b0, 1'b0, 1'b0, 32'h0, 5, 1'b0);
    run_evt("R2 zero hits", 4'h3, 8'd0, 1'b0, 1'b0, 1'b0, 32'h0, 0, 1'b0);
    run_evt("R2 63 hits", 4'h6, 8'd63, 1'b0, 1'b0, 1'b0, 32'h0, 63, 1'b0);
    run_evt("R4 64 hits", 4'h9, 8'd64, 1'b0, 1'b0, 1'b0, 32'h0, 0, 1'b0);
    run_evt("R4 200 hits", 4'h1, 8'd200, 1'b0, 1'b0, 1'b0, 32'h0, 0, 1'b0);
    run_evt("R5 full+raw", 4'hC, 8'd70, 1'b1, 1'b1, 1'b0, 32'h12345678, 0, 1'b0);
    run_evt("R6 fill", 4'h2, 8'd5, 1'b1, 1'b1, 1'b1, 32'h0, 0, 1'b0);
    run_evt("R7 raw", 4'h5, 8'd3, 1'b1, 1'b0, 1'b0, 32'hA1B2C3F4, 128, 1'b0);
    run_evt("R9 strobe while busy", 4'h7, 8'd4, 1'b0, 1'b0, 1'b0, 32'h0, 4, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule